// File: doc/BRIEF.md
# Symmetric Pre-Add Decimating FIR Cell

This block is a single eight-tap FIR filter for 10-bit signed samples. In its folded (symmetric) mode the two samples that share a mirrored coefficient are added first, so only four multipliers produce the whole eight-tap result in one cycle. In its unfolded (asymmetric) mode the same four multipliers are used twice: the first beat covers the four newest taps and the second beat the four oldest. Each tap then has its own coefficient.

Coefficients live in a bank of 32 sets of eight words. A 5-bit set-select input is captured together with each sample that produces an output, so the active set can change on every clock. This suits polyphase and adaptive use. A decimation counter produces one result per N accepted samples, where N is 1 to 16. The result can be rounded half-up at a programmable bit position. All settings and coefficients are written through a 9-bit address, 10-bit data register port.

Top module: `sympre_fir_cell`

## Requirements
- R1: In folded mode, y = sum over k=0..3 of c[k]*(x[n-k] + x[n-7+k]), where x[n] is the newest accepted sample and c[k] is slot k of the selected set (slots 4..7 unused). If the sample that completes a decimation period is presented in cycle t, out_valid is high in cycle t+2.
- R2: In unfolded mode (mode register bit 0 = 1), y = sum over k=0..7 of c[k]*x[n-k] and out_valid is high in cycle t+3. In this mode the cycle after a sample that completes a period must carry no sample.
- R3: Samples and coefficients are 10-bit two's complement. The 24-bit result never overflows, even with every operand at -512.
- R4: A write with wr_addr[8]=0 stores wr_data into set wr_addr[7:3], slot wr_addr[2:0].
- R5: set_sel is captured in the cycle of the sample that completes a period, and that set is used for the result. set_sel may change on every cycle.
- R6: A write to address 0x100 sets N-1 from wr_data[3:0]. out_valid rises once per N accepted samples, counted from reset or from the last write to 0x100.
- R7: A write to address 0x101 sets r from wr_data[4:0]. out_data = floor((y + 2^(r-1)) / 2^r); with r=0 it is y itself. Values of r above 23 act as 23.
- R8: A write to address 0x102 sets the mode from wr_data[0] (0 folded, 1 unfolded). After reset the block is in folded mode with N=1, r=0, all coefficients 0 and all taps 0.
- R9: The bank is read in the cycle after the completing sample, and in unfolded mode again in the cycle after that. A coefficient write in a reading cycle is seen only by later reads.
- R10: During reset out_valid is 0 and out_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe; in_data is accepted when high |
| in_data | input | 10 | Signed sample |
| set_sel | input | 5 | Coefficient set for the result this sample completes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Write address: bit 8 low for coefficients, high for settings |
| wr_data | input | 10 | Write data |
| out_valid | output | 1 | Result strobe |
| out_data | output | 24 | Signed, rounded result |

## Verification
The critical collision is a coefficient write that lands in the same cycle as a bank read, while set_sel changes on every clock. The sweep writes coefficients every few cycles into rotating sets while samples stream in, so many writes hit the set that a pending result is reading. In unfolded mode writes also hit the gap cycle between the two beats. The bench model applies each write at the clock edge after the read it must miss and before the read it must reach. A result is judged both on its value and on whether out_valid rises in exactly the cycle the model predicts.

// File: rtl/sympre_fir_pkg.sv
package sympre_fir_pkg;

  typedef enum logic {
    MODE_FOLD   = 1'b0,
    MODE_UNFOLD = 1'b1
  } fir_mode_e;

  // setting register index, low address bits with bit 8 high
  localparam logic [1:0] CFG_DECIM = 2'd0;
  localparam logic [1:0] CFG_ROUND = 2'd1;
  localparam logic [1:0] CFG_MODE  = 2'd2;

  // round half up at bit r, then arithmetic shift; r = 0 passes through
  function automatic logic signed [31:0] round_half_up(input logic signed [31:0] v,
                                                       input logic [4:0] r);
    logic signed [31:0] half;
    half = (r == 5'd0) ? 32'sd0 : (32'sd1 <<< (r - 5'd1));
    return (v + half) >>> r;
  endfunction

endpackage

// File: rtl/sympre_fir_bank.sv
module sympre_fir_bank #(
  parameter int COEF_W = 10,
  parameter int TAPS   = 8,
  parameter int NSETS  = 32,
  parameter int SET_W  = $clog2(NSETS),
  parameter int SLOT_W = $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [SET_W-1:0]         wset,
  input  logic [SLOT_W-1:0]        wslot,
  input  logic signed [COEF_W-1:0] wdata,
  input  logic [SET_W-1:0]         rset,
  output logic signed [COEF_W-1:0] rcoef [TAPS]
);
  localparam int WORDS = NSETS * TAPS;

  logic signed [COEF_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[int'(wset) * TAPS + int'(wslot)] <= wdata;
    end
  end

  always_comb begin
    for (int k = 0; k < TAPS; k++) rcoef[k] = mem[int'(rset) * TAPS + k];
  end
endmodule

// File: rtl/sympre_fir_decim.sv
module sympre_fir_decim #(
  parameter int DEC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             clr,
  input  logic [DEC_W-1:0] dec_m1,
  output logic             fire
);
  logic [DEC_W-1:0] cnt_q;

  assign fire = accept && !clr && (cnt_q == dec_m1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (accept)   cnt_q <= (cnt_q == dec_m1) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/sympre_fir_mac.sv
module sympre_fir_mac #(
  parameter int DATA_W = 10,
  parameter int COEF_W = 10,
  parameter int TAPS   = 8,
  parameter int SUM_W  = 24
) (
  input  logic                     unfold,
  input  logic                     back,
  input  logic signed [DATA_W-1:0] tap  [TAPS],
  input  logic signed [COEF_W-1:0] coef [TAPS],
  output logic signed [SUM_W-1:0]  psum
);
  localparam int HALF   = TAPS / 2;
  localparam int OPA_W  = DATA_W + 1;
  localparam int PROD_W = OPA_W + COEF_W;

  logic signed [PROD_W-1:0] prod [HALF];

  for (genvar k = 0; k < HALF; k++) begin : g_mult
    logic signed [OPA_W-1:0]  opa;
    logic signed [COEF_W-1:0] cf;
    always_comb begin
      if (!unfold) begin
        opa = OPA_W'(tap[k]) + OPA_W'(tap[TAPS-1-k]);
        cf  = coef[k];
      end else if (back) begin
        opa = OPA_W'(tap[TAPS-1-k]);
        cf  = coef[TAPS-1-k];
      end else begin
        opa = OPA_W'(tap[k]);
        cf  = coef[k];
      end
    end
    assign prod[k] = opa * cf;
  end

  always_comb begin
    psum = '0;
    for (int k = 0; k < HALF; k++) psum = psum + SUM_W'(prod[k]);
  end
endmodule

// File: rtl/sympre_fir_cell.sv
module sympre_fir_cell
  import sympre_fir_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int COEF_W  = 10,
  parameter int ACC_W   = 24,
  parameter int NSETS   = 32,
  parameter int DEC_MAX = 16,
  parameter int ADDR_W  = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [DATA_W-1:0]       in_data,
  input  logic [$clog2(NSETS)-1:0] set_sel,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [COEF_W-1:0]       wr_data,
  output logic                    out_valid,
  output logic [ACC_W-1:0]        out_data
);
  localparam int TAPS   = 8;
  localparam int SET_W  = $clog2(NSETS);
  localparam int SLOT_W = $clog2(TAPS);
  localparam int DEC_W  = $clog2(DEC_MAX);
  localparam int RND_W  = $clog2(ACC_W);
  localparam logic [RND_W-1:0] RND_TOP = RND_W'(ACC_W - 1);

  // ---------------- register port decode ----------------
  logic cfg_hit, coef_we, dec_we;
  assign cfg_hit = wr_en && wr_addr[ADDR_W-1] && (wr_addr[ADDR_W-2:2] == '0);
  assign coef_we = wr_en && !wr_addr[ADDR_W-1];
  assign dec_we  = cfg_hit && (wr_addr[1:0] == CFG_DECIM);

  fir_mode_e        mode_q;
  logic [DEC_W-1:0] dec_m1_q;
  logic [RND_W-1:0] rnd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_FOLD;
      dec_m1_q <= '0;
      rnd_q    <= '0;
    end else if (cfg_hit) begin
      case (wr_addr[1:0])
        CFG_DECIM: dec_m1_q <= wr_data[DEC_W-1:0];
        CFG_ROUND: rnd_q    <= wr_data[RND_W-1:0];
        CFG_MODE:  mode_q   <= fir_mode_e'(wr_data[0]);
        default:   ;
      endcase
    end
  end

  logic mode_unfold;
  assign mode_unfold = (mode_q == MODE_UNFOLD);

  // ---------------- sample delay line ----------------
  logic signed [DATA_W-1:0] tap_q [TAPS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) tap_q[k] <= '0;
    end else if (in_valid) begin
      tap_q[0] <= $signed(in_data);
      for (int k = 1; k < TAPS; k++) tap_q[k] <= tap_q[k-1];
    end
  end

  // ---------------- decimation and sequencing ----------------
  logic fire;
  sympre_fir_decim #(.DEC_W(DEC_W)) u_decim (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (in_valid),
    .clr    (dec_we),
    .dec_m1 (dec_m1_q),
    .fire   (fire)
  );

  logic             go_q, back_q;
  logic [SET_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      back_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      go_q   <= fire;
      back_q <= go_q && mode_unfold;
      if (fire) sel_q <= set_sel;
    end
  end

  // ---------------- coefficient bank ----------------
  logic signed [COEF_W-1:0] coef [TAPS];
  sympre_fir_bank #(
    .COEF_W (COEF_W),
    .TAPS   (TAPS),
    .NSETS  (NSETS),
    .SET_W  (SET_W),
    .SLOT_W (SLOT_W)
  ) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (coef_we),
    .wset  (wr_addr[SLOT_W +: SET_W]),
    .wslot (wr_addr[SLOT_W-1:0]),
    .wdata ($signed(wr_data)),
    .rset  (sel_q),
    .rcoef (coef)
  );

  // ---------------- pre-add, multiply, accumulate ----------------
  logic signed [ACC_W-1:0] psum, partial_q, acc_full;

  sympre_fir_mac #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .TAPS   (TAPS),
    .SUM_W  (ACC_W)
  ) u_mac (
    .unfold (mode_unfold),
    .back   (back_q),
    .tap    (tap_q),
    .coef   (coef),
    .psum   (psum)
  );

  assign acc_full = back_q ? (partial_q + psum) : psum;

  always_ff @(posedge clk) begin
    if (!rst_n)                   partial_q <= '0;
    else if (go_q && mode_unfold) partial_q <= psum;
  end

  // ---------------- rounding and output ----------------
  logic [RND_W-1:0] rnd_eff;
  logic             result_now;
  assign rnd_eff    = (rnd_q > RND_TOP) ? RND_TOP : rnd_q;
  assign result_now = (go_q && !mode_unfold) || back_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= result_now;
      if (result_now)
        out_data <= ACC_W'(round_half_up(32'(acc_full), 5'(rnd_eff)));
    end
  end
endmodule

// File: rtl/sympre_fir_cell_chk.sv
module sympre_fir_cell_chk #(
  parameter int ACC_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             fire,
  input logic             go_q,
  input logic             back_q,
  input logic             mode_unfold,
  input logic             out_valid,
  input logic [ACC_W-1:0] acc_full
);
  AST_FIRE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> in_valid); // R6

  AST_FOLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && !mode_unfold) |=> out_valid); // R1

  AST_UNFOLD_SECOND_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && mode_unfold) |=> (back_q && !out_valid)); // R2

  AST_UNFOLD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && mode_unfold) |-> !in_valid); // R2

  AST_BEATS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_q, back_q})); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q || back_q) |-> (acc_full[ACC_W-1] == acc_full[ACC_W-2])); // R3
endmodule

bind sympre_fir_cell sympre_fir_cell_chk #(.ACC_W(ACC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .fire        (fire),
  .go_q        (go_q),
  .back_q      (back_q),
  .mode_unfold (mode_unfold),
  .out_valid   (out_valid),
  .acc_full    (acc_full)
);

// File: tb/sympre_fir_cell_tb.sv
module sympre_fir_cell_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [9:0] in_data = '0;
  logic [4:0] set_sel = '0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic       out_valid;
  logic [23:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  sympre_fir_cell u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .set_sel(set_sel), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int vectors = 0;
  int miscompares = 0;

  // ---------------- reference model state ----------------
  longint hist [8];
  longint cmem [256];
  bit     m_unfold = 0;
  int     m_dec = 0;
  int     m_rnd = 0;
  int     m_cnt = 0;
  bit     pend_go = 0, pend_b = 0;
  int     m_sel = 0;
  longint m_part = 0;
  bit     pushed = 0;
  longint exp_val = 0;
  string  cur_req = "R8";

  function automatic longint ref_round(longint y, int r);
    longint q, d;
    if (r > 23) r = 23;
    if (r == 0) return y;
    d = longint'(1) << r;
    q = y + d / 2;
    if (q >= 0) return q / d;
    return -((-q + d - 1) / d);
  endfunction

  function automatic longint dot(int s, int lo, int hi);
    longint acc = 0;
    for (int k = lo; k <= hi; k++) acc += cmem[s*8 + k] * hist[k];
    return acc;
  endfunction

  function automatic longint folded(int s);
    longint acc = 0;
    for (int k = 0; k < 4; k++) acc += cmem[s*8 + k] * (hist[k] + hist[7-k]);
    return acc;
  endfunction

  task automatic check(bit ok, string req, longint act, longint expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // model advances on the same edge as the design
  always @(posedge clk) begin
    pushed = 0;
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) hist[k] = 0;
      for (int i = 0; i < 256; i++) cmem[i] = 0;
      m_unfold = 0; m_dec = 0; m_rnd = 0; m_cnt = 0;
      pend_go = 0; pend_b = 0; m_sel = 0; m_part = 0;
    end else begin
      bit decw, firing;
      // reads of this cycle see the bank before this edge's write (R9)
      if (pend_b) begin
        exp_val = ref_round(m_part + dot(m_sel, 4, 7), m_rnd);
        pushed = 1; pend_b = 0;
      end
      if (pend_go) begin
        if (!m_unfold) begin
          exp_val = ref_round(folded(m_sel), m_rnd);
          pushed = 1;
        end else begin
          m_part = dot(m_sel, 0, 3);
          pend_b = 1;
        end
        pend_go = 0;
      end
      decw = wr_en && wr_addr[8] && (wr_addr[7:2] == 0) && (wr_addr[1:0] == 2'd0);
      firing = in_valid && !decw && (m_cnt == m_dec);
      if (wr_en && !wr_addr[8]) cmem[wr_addr[7:0]] = longint'($signed(wr_data));
      if (wr_en && wr_addr[8] && (wr_addr[7:2] == 0)) begin
        case (wr_addr[1:0])
          2'd0: m_dec = int'(wr_data[3:0]);
          2'd1: m_rnd = int'(wr_data[4:0]);
          2'd2: m_unfold = wr_data[0];
          default: ;
        endcase
      end
      if (decw) m_cnt = 0;
      else if (in_valid) m_cnt = (m_cnt == m_dec) ? 0 : m_cnt + 1;
      if (in_valid) begin
        for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = longint'($signed(in_data));
      end
      if (firing) begin
        pend_go = 1;
        m_sel = int'(set_sel);
      end
    end
  end

  // outputs are judged half a period after the edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid != pushed)
        check(0, {cur_req, " out_valid timing"}, longint'(out_valid), longint'(pushed));
      else if (pushed)
        check(longint'($signed(out_data)) == exp_val, cur_req,
              longint'($signed(out_data)), exp_val);
    end
  end

  task automatic cyc(input bit v, input int d, input int s,
                     input bit we, input int a, input int wd);
    @(negedge clk);
    in_valid = v;
    in_data  = 10'(d);
    set_sel  = 5'(s);
    wr_en    = we;
    wr_addr  = 9'(a);
    wr_data  = 10'(wd);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic cfg(input int idx, input int val);
    cyc(0, 0, 0, 1, 256 + idx, val);
  endtask

  function automatic int coef_fn(int s, int t);
    if (s == 31) return -512;
    return ((s*37 + t*53 + 11) % 1024) - 512;
  endfunction

  function automatic int samp(int i);
    if (i % 11 == 0) return 511;
    if (i % 13 == 0) return -512;
    return ((i*97 + 13) % 1024) - 512;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int decs [6] = '{1, 2, 3, 5, 8, 16};
    int rnds [6] = '{0, 1, 4, 9, 23, 31};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: quiet outputs during reset
    check(out_valid == 1'b0, "R10 out_valid", longint'(out_valid), 0);
    check(out_data == '0, "R10 out_data", longint'(out_data), 0);
    rst_n = 1'b1;

    // R4: fill every set through the address map {set, slot}
    for (int s = 0; s < 32; s++)
      for (int t = 0; t < 8; t++)
        cyc(0, 0, 0, 1, s*8 + t, coef_fn(s, t));

    // R3 R8: defaults (folded, N=1, r=0) with worst-case operands
    cur_req = "R3 R8";
    for (int i = 0; i < 12; i++) cyc(1, -512, 31, 0, 0, 0);
    for (int i = 0; i < 12; i++) cyc(1, 511, 31, 0, 0, 0);
    idle(4);
    cfg(2, 1);
    cur_req = "R3 R2";
    for (int i = 0; i < 12; i++) begin
      cyc(1, -512, 31, 0, 0, 0);
      idle(1);
    end
    idle(4);
    cfg(2, 0);

    // R9: write into the set being read, in the read cycle
    cur_req = "R9";
    cyc(1, 100, 5, 0, 0, 0);
    cyc(1, -200, 6, 1, 5*8 + 0, 77);
    cyc(1, 300, 5, 1, 5*8 + 1, -300);
    cyc(0, 0, 0, 1, 5*8 + 2, 12);
    idle(4);

    // R1 R2 R5 R6 R7: sweep mode x decimation x rounding
    for (int m = 0; m < 2; m++) begin
      for (int di = 0; di < 6; di++) begin
        idle(6);
        cfg(2, m);
        cfg(0, decs[di] - 1);
        cfg(1, rnds[di]);
        cur_req = m ? "R2 R5 R6 R7 R9" : "R1 R5 R6 R7 R9";
        for (int j = 0; j < 48; j++) begin
          bit v  = !(m == 0 && j % 9 == 8);
          bit we = (j % 5 == 2);
          int wa = ((j*3) % 31) * 8 + (j % 8);
          cyc(v, samp(j + 7*di + 50*m), (j*7 + m + di) % 32, we, wa, ((j*29) % 1024) - 512);
          if (m == 1) cyc(0, 0, (j*11) % 32, j % 5 == 4, wa, (j*41 % 1024) - 512);
        end
      end
    end

    // R6: a rewrite of the decimation register restarts the count
    idle(6);
    cfg(2, 0);
    cfg(0, 3);
    cur_req = "R6";
    for (int j = 0; j < 3; j++) cyc(1, samp(j), 2, 0, 0, 0);
    cfg(0, 3);
    for (int j = 0; j < 9; j++) cyc(1, samp(j + 3), 2, 0, 0, 0);
    idle(6);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule